// File: doc/BRIEF.md
# Vector Load/Store Address Sequencer

This block takes one scalar load or store that has been widened over a vector and steps through its elements. For each element it produces one effective address, plus an optional value to write back to the base register. A start strobe hands it the vector length, the addressing form, per-operand vector flags, the access size, an immediate, a source-element width and two predicate masks. It then issues one element per cycle to the memory stage under a valid/ready handshake.

Base and offset registers are fetched through a combinational register-read port. The block puts out an element selector for the base operand and one for the offset operand, and the register file returns both values in the same cycle. Each operand has its own element index. An index skips elements whose predicate bit is clear, but only when that operand is a vector. The base, offset and update operands follow the source predicate. The destination follows the destination predicate.

Memory access, data formatting and fault handling are done elsewhere.

Top module: `vls_addr_seq`

## Requirements
- R1: The `out_mode` code reports the addressing form chosen for the run:
  - 0 unit-stride, 1 element-stride, 2 vector base, 3 splat, 4 post-increment, 5 indexed, 6 indexed-stride.
  - In the immediate form, post-increment takes precedence. After that the order is: a vector base gives 2; a clear stride bit gives 0; a set stride bit gives 1 with a nonzero immediate and 3 with a zero immediate.
  - In the indexed form the result is 6 when the stride bit is set and both base and offset are scalar, and 5 otherwise.
- R2: In unit-stride mode the address is base + sign-extended immediate + d × size. Here d is the destination element index, and size is 1, 2, 4 or 8 bytes for `op_size` codes 0 to 3.
- R3: In element-stride mode the address is base + d × sign-extended immediate.
- R4: In vector-base mode and in splat mode the address is base + immediate. The base is element i of the base register when the base is a vector, and element 0 otherwise.
- R5: In post-increment mode the address is the unmodified base and the write-back value is base + immediate.
- R6: In indexed mode the address is base[i] + offset[k]. In indexed-stride mode it is base + offset × d.
- R7: The offset is cut to the source element width (`src_ew` 0/1/2/3 = 8/16/32/64 bits). It is then sign-extended when `sea` is set and zero-extended otherwise. The base always uses all 64 bits.
- R8: Source-side indices skip elements whose source-mask bit is clear, and the destination index skips elements whose destination-mask bit is clear; in both cases only for vector operands. The run ends as soon as any active index reaches the vector length.
- R9: A scalar destination ends the run after exactly one element.
- R10: While `out_valid` is high and `out_ready` is low, the output element is held unchanged. At most one element is issued per cycle.
- R11: After reset `out_valid`, `busy` and `done` are low. `done` pulses for one cycle when a run ends. A vector length of zero gives `done` with no element.
- R12: When `upd_en` is set, `out_wb_en` is high with each element. Outside post-increment mode, `out_wb_val` equals the element's address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (ignored while busy) |
| vl | input | IW | Vector length |
| idx_form | input | 1 | 1 = register+register form, 0 = immediate form |
| ra_vec | input | 1 | Base operand is a vector |
| rb_vec | input | 1 | Offset operand is a vector |
| rt_vec | input | 1 | Destination is a vector |
| upd_en | input | 1 | Base-register write-back requested |
| upd_vec | input | 1 | Write-back target is a vector |
| els | input | 1 | Element-stride select |
| postinc | input | 1 | Post-increment select |
| sea | input | 1 | Sign-extend the offset |
| op_size | input | 2 | Access size code |
| src_ew | input | 2 | Source element width code |
| imm | input | IMM_W | Immediate |
| src_mask | input | MAXVL | Source predicate |
| dst_mask | input | MAXVL | Destination predicate |
| rd_a_sel | output | IW | Base element selector |
| rd_a_val | input | 64 | Base value |
| rd_b_sel | output | IW | Offset element selector |
| rd_b_val | input | 64 | Offset value |
| out_valid | output | 1 | Element valid |
| out_ready | input | 1 | Memory stage accepts |
| out_addr | output | 64 | Effective address |
| out_mode | output | 3 | Addressing form code |
| out_src_idx | output | IW | Base element index |
| out_off_idx | output | IW | Offset element index |
| out_dst_idx | output | IW | Destination element index |
| out_upd_idx | output | IW | Write-back element index |
| out_wb_en | output | 1 | Write-back enable |
| out_wb_val | output | 64 | Write-back value |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run-end pulse |

## Verification
Back-pressure and loop termination can land in the same cycle. The sequencer only tests for the end condition when the current element is taken, so a stall on the last element has to keep that element on the outputs and must not raise `done`. The bench provokes this case with a ready pattern that drops low periodically, including on final elements. It checks that the held address stays stable, that the element count matches, and that `done` comes only after the last acceptance.

// File: rtl/vls_pkg.sv
package vls_pkg;
  typedef enum logic [2:0] {
    AM_UNIT    = 3'd0,
    AM_ESTRIDE = 3'd1,
    AM_VBASE   = 3'd2,
    AM_SPLAT   = 3'd3,
    AM_POSTINC = 3'd4,
    AM_XINDEX  = 3'd5,
    AM_XSTRIDE = 3'd6
  } amode_t;

  typedef struct packed {
    logic idx_form;
    logic ra_vec;
    logic rb_vec;
    logic rt_vec;
    logic upd_en;
    logic upd_vec;
    logic els;
    logic postinc;
    logic sea;
  } seq_cfg_t;
endpackage

// File: rtl/vls_mode_dec.sv
module vls_mode_dec
  import vls_pkg::*;
(
  input  seq_cfg_t cfg,
  input  logic     imm_nz,
  output amode_t   mode
);
  always_comb begin
    if (cfg.idx_form)
      mode = (cfg.els && !cfg.ra_vec && !cfg.rb_vec) ? AM_XSTRIDE : AM_XINDEX;
    else if (cfg.postinc)
      mode = AM_POSTINC;
    else if (cfg.ra_vec)
      mode = AM_VBASE;
    else if (!cfg.els)
      mode = AM_UNIT;
    else if (imm_nz)
      mode = AM_ESTRIDE;
    else
      mode = AM_SPLAT;
  end
endmodule

// File: rtl/vls_next_elem.sv
module vls_next_elem #(
  parameter int MAXVL = 16,
  localparam int IW = $clog2(MAXVL + 1)
) (
  input  logic [IW-1:0]    cur,
  input  logic [MAXVL-1:0] mask,
  input  logic             is_vec,
  input  logic [IW-1:0]    vl,
  output logic [IW-1:0]    nxt
);
  always_comb begin
    logic found;
    found = 1'b0;
    nxt   = is_vec ? vl : cur;
    for (int p = 0; p < MAXVL; p++) begin
      if (is_vec && !found && IW'(p) >= cur && IW'(p) < vl && mask[p]) begin
        nxt   = IW'(p);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vls_addr_seq.sv
module vls_addr_seq
  import vls_pkg::*;
#(
  parameter int MAXVL = 16,
  parameter int IMM_W = 16,
  localparam int IW = $clog2(MAXVL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IW-1:0]    vl,
  input  logic             idx_form,
  input  logic             ra_vec,
  input  logic             rb_vec,
  input  logic             rt_vec,
  input  logic             upd_en,
  input  logic             upd_vec,
  input  logic             els,
  input  logic             postinc,
  input  logic             sea,
  input  logic [1:0]       op_size,
  input  logic [1:0]       src_ew,
  input  logic [IMM_W-1:0] imm,
  input  logic [MAXVL-1:0] src_mask,
  input  logic [MAXVL-1:0] dst_mask,
  output logic [IW-1:0]    rd_a_sel,
  input  logic [63:0]      rd_a_val,
  output logic [IW-1:0]    rd_b_sel,
  input  logic [63:0]      rd_b_val,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [63:0]      out_addr,
  output logic [2:0]       out_mode,
  output logic [IW-1:0]    out_src_idx,
  output logic [IW-1:0]    out_off_idx,
  output logic [IW-1:0]    out_dst_idx,
  output logic [IW-1:0]    out_upd_idx,
  output logic             out_wb_en,
  output logic [63:0]      out_wb_val,
  output logic             busy,
  output logic             done
);
  localparam int NOPS = 4;
  localparam int OP_A = 0;
  localparam int OP_B = 1;
  localparam int OP_U = 2;
  localparam int OP_D = 3;

  seq_cfg_t         cfg_q;
  logic [IW-1:0]    vl_q;
  logic [1:0]       opsz_q;
  logic [1:0]       ew_q;
  logic [IMM_W-1:0] imm_q;
  logic [MAXVL-1:0] ps_q;
  logic [MAXVL-1:0] pd_q;
  logic             busy_q;
  logic [IW-1:0]    cur_q [NOPS];
  logic [IW-1:0]    nxt_c [NOPS];
  logic             vec_c [NOPS];
  amode_t           mode_c;
  logic             cfg_rt_vec;

  assign vec_c[OP_A] = cfg_q.ra_vec;
  assign vec_c[OP_B] = cfg_q.rb_vec;
  assign vec_c[OP_U] = cfg_q.upd_vec;
  assign vec_c[OP_D] = cfg_q.rt_vec;
  assign cfg_rt_vec  = cfg_q.rt_vec;

  for (genvar g = 0; g < NOPS; g++) begin : g_step
    vls_next_elem #(.MAXVL(MAXVL)) u_step (
      .cur    (cur_q[g]),
      .mask   ((g == OP_D) ? pd_q : ps_q),
      .is_vec (vec_c[g]),
      .vl     (vl_q),
      .nxt    (nxt_c[g])
    );
  end

  vls_mode_dec u_mode (
    .cfg    (cfg_q),
    .imm_nz (|imm_q),
    .mode   (mode_c)
  );

  assign rd_a_sel = cfg_q.ra_vec ? nxt_c[OP_A] : '0;
  assign rd_b_sel = cfg_q.rb_vec ? nxt_c[OP_B] : '0;
  assign busy     = busy_q;

  function automatic logic [63:0] ext_off(input logic [63:0] v, input logic [1:0] ew,
                                          input logic sgn);
    case (ew)
      2'd0:    ext_off = sgn ? {{56{v[7]}}, v[7:0]}   : {56'd0, v[7:0]};
      2'd1:    ext_off = sgn ? {{48{v[15]}}, v[15:0]} : {48'd0, v[15:0]};
      2'd2:    ext_off = sgn ? {{32{v[31]}}, v[31:0]} : {32'd0, v[31:0]};
      default: ext_off = v;
    endcase
  endfunction

  logic [63:0] imm64, dst64, off64, addr_c, wb_c;
  logic        end_now, adv;

  assign imm64 = {{(64-IMM_W){imm_q[IMM_W-1]}}, imm_q};
  assign dst64 = {{(64-IW){1'b0}}, nxt_c[OP_D]};
  assign off64 = ext_off(rd_b_val, ew_q, cfg_q.sea);

  always_comb begin
    addr_c = rd_a_val;
    case (mode_c)
      AM_UNIT:    addr_c = rd_a_val + imm64 + (dst64 << opsz_q);
      AM_ESTRIDE: addr_c = rd_a_val + dst64 * imm64;
      AM_VBASE,
      AM_SPLAT:   addr_c = rd_a_val + imm64;
      AM_XINDEX:  addr_c = rd_a_val + off64;
      AM_XSTRIDE: addr_c = rd_a_val + off64 * dst64;
      default:    addr_c = rd_a_val;
    endcase
    wb_c = (mode_c == AM_POSTINC) ? rd_a_val + imm64 : addr_c;
  end

  assign end_now = (nxt_c[OP_A] >= vl_q)
                 || (cfg_q.idx_form && nxt_c[OP_B] >= vl_q)
                 || (cfg_q.upd_en && nxt_c[OP_U] >= vl_q)
                 || (nxt_c[OP_D] >= vl_q);
  assign adv = busy_q && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q      <= 1'b0;
      done        <= 1'b0;
      out_valid   <= 1'b0;
      out_addr    <= '0;
      out_mode    <= '0;
      out_src_idx <= '0;
      out_off_idx <= '0;
      out_dst_idx <= '0;
      out_upd_idx <= '0;
      out_wb_en   <= 1'b0;
      out_wb_val  <= '0;
      cfg_q       <= '0;
      vl_q        <= '0;
      opsz_q      <= '0;
      ew_q        <= '0;
      imm_q       <= '0;
      ps_q        <= '0;
      pd_q        <= '0;
      for (int g = 0; g < NOPS; g++) cur_q[g] <= '0;
    end else begin
      done <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          cfg_q  <= '{idx_form: idx_form, ra_vec: ra_vec, rb_vec: rb_vec,
                      rt_vec: rt_vec, upd_en: upd_en, upd_vec: upd_vec,
                      els: els, postinc: postinc, sea: sea};
          vl_q   <= vl;
          opsz_q <= op_size;
          ew_q   <= src_ew;
          imm_q  <= imm;
          ps_q   <= src_mask;
          pd_q   <= dst_mask;
          for (int g = 0; g < NOPS; g++) cur_q[g] <= '0;
        end
      end else if (adv) begin
        if (end_now) begin
          busy_q    <= 1'b0;
          done      <= 1'b1;
          out_valid <= 1'b0;
        end else begin
          out_valid   <= 1'b1;
          out_addr    <= addr_c;
          out_mode    <= mode_c;
          out_src_idx <= nxt_c[OP_A];
          out_off_idx <= nxt_c[OP_B];
          out_dst_idx <= nxt_c[OP_D];
          out_upd_idx <= nxt_c[OP_U];
          out_wb_en   <= cfg_q.upd_en;
          out_wb_val  <= wb_c;
          for (int g = 0; g < OP_D; g++)
            cur_q[g] <= vec_c[g] ? nxt_c[g] + 1'b1 : nxt_c[g];
          cur_q[OP_D] <= cfg_q.rt_vec ? nxt_c[OP_D] + 1'b1 : vl_q;
        end
      end
    end
  end
endmodule

// File: rtl/vls_addr_seq_chk.sv
module vls_addr_seq_chk #(
  parameter int MAXVL = 16,
  localparam int IW = $clog2(MAXVL + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             out_valid,
  input logic             out_ready,
  input logic [63:0]      out_addr,
  input logic [IW-1:0]    out_dst_idx,
  input logic             done,
  input logic             busy,
  input logic             rt_vec_q,
  input logic [MAXVL-1:0] dst_mask_q,
  input logic [IW-1:0]    vl_q
);
  // R10: a stalled element stays put
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_dst_idx));

  // R11: done is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11: done comes with an idle sequencer and no pending element
  p_done_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> !out_valid && !busy);

  // R8: a vector destination never lands on a masked element
  p_dst_mask_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid && rt_vec_q |-> dst_mask_q[out_dst_idx]);

  // R8: the destination index stays below the vector length
  p_below_vl_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_dst_idx < vl_q);

  // R9: a scalar destination only ever uses element 0
  p_scalar_one_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !rt_vec_q |-> out_dst_idx == '0);
endmodule

bind vls_addr_seq vls_addr_seq_chk #(.MAXVL(MAXVL)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_addr    (out_addr),
  .out_dst_idx (out_dst_idx),
  .done        (done),
  .busy        (busy),
  .rt_vec_q    (cfg_rt_vec),
  .dst_mask_q  (pd_q),
  .vl_q        (vl_q)
);

// File: tb/vls_addr_seq_test.sv
module vls_addr_seq_test;
  localparam int MAXVL = 16;
  localparam int IMM_W = 16;
  localparam int IW = $clog2(MAXVL + 1);
  localparam int NROWS = 17;

  typedef struct packed {
    logic idxf; logic rav; logic rbv; logic rtv; logic upe; logic upv;
    logic els; logic pi; logic sea;
    logic [1:0] opsz; logic [1:0] ew; logic [15:0] imm; logic [4:0] vl;
    logic [15:0] ps; logic [15:0] pd; logic [4:0] n; logic [2:0] mode; logic bp;
  } row_t;

  localparam row_t ROWS [NROWS] = '{
    '{0,0,0,1,0,0,0,0,0,2'd3,2'd3,16'h0010,5'd4,16'hFFFF,16'hFFFF,5'd4,3'd0,0},
    '{0,0,0,1,0,0,0,0,0,2'd1,2'd3,16'h0010,5'd4,16'hFFFF,16'h000A,5'd2,3'd0,1},
    '{0,0,0,1,0,0,1,0,0,2'd2,2'd3,16'h0030,5'd5,16'hFFFF,16'hFFFF,5'd5,3'd1,0},
    '{0,0,0,1,0,0,1,0,0,2'd2,2'd3,16'hFFF0,5'd3,16'hFFFF,16'hFFFF,5'd3,3'd1,1},
    '{0,0,0,1,0,0,1,0,0,2'd3,2'd3,16'h0000,5'd3,16'hFFFF,16'hFFFF,5'd3,3'd3,0},
    '{0,1,0,1,0,0,0,0,0,2'd3,2'd3,16'h0008,5'd4,16'h0005,16'hFFFF,5'd2,3'd2,0},
    '{0,0,0,1,1,0,0,1,0,2'd3,2'd3,16'h0020,5'd3,16'hFFFF,16'hFFFF,5'd3,3'd4,1},
    '{0,0,0,0,0,0,0,0,0,2'd3,2'd3,16'h0010,5'd4,16'hFFFF,16'hFFFF,5'd1,3'd0,0},
    '{1,0,1,1,0,0,0,0,0,2'd3,2'd3,16'h0000,5'd4,16'h000F,16'hFFFF,5'd4,3'd5,0},
    '{1,0,1,1,0,0,0,0,1,2'd3,2'd0,16'h0000,5'd3,16'hFFFF,16'hFFFF,5'd3,3'd5,1},
    '{1,0,1,1,0,0,0,0,0,2'd3,2'd0,16'h0000,5'd2,16'hFFFF,16'hFFFF,5'd2,3'd5,0},
    '{1,0,1,1,0,0,0,0,1,2'd3,2'd1,16'h0000,5'd2,16'hFFFF,16'hFFFF,5'd2,3'd5,0},
    '{1,0,0,1,0,0,1,0,0,2'd3,2'd2,16'h0000,5'd4,16'hFFFF,16'h000D,5'd3,3'd6,1},
    '{0,1,0,1,1,1,0,0,0,2'd3,2'd3,16'h0004,5'd3,16'h0006,16'hFFFF,5'd2,3'd2,0},
    '{0,0,0,1,0,0,0,0,0,2'd3,2'd3,16'h0000,5'd0,16'hFFFF,16'hFFFF,5'd0,3'd0,0},
    '{1,0,1,1,0,0,1,0,0,2'd3,2'd3,16'h0000,5'd2,16'hFFFF,16'hFFFF,5'd2,3'd5,0},
    '{0,1,0,1,0,0,1,0,0,2'd3,2'd3,16'h0010,5'd2,16'hFFFF,16'hFFFF,5'd2,3'd2,0}
  };

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [IW-1:0] vl = '0;
  logic idx_form = 0, ra_vec = 0, rb_vec = 0, rt_vec = 0, upd_en = 0, upd_vec = 0;
  logic els = 0, postinc = 0, sea = 0, out_ready = 1'b1;
  logic [1:0] op_size = '0, src_ew = '0;
  logic [IMM_W-1:0] imm = '0;
  logic [MAXVL-1:0] src_mask = '0, dst_mask = '0;
  logic [IW-1:0] rd_a_sel, rd_b_sel, out_src_idx, out_off_idx, out_dst_idx, out_upd_idx;
  logic [63:0] rd_a_val, rd_b_val, out_addr, out_wb_val;
  logic out_valid, out_wb_en, busy, done;
  logic [2:0] out_mode;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  function automatic logic [63:0] a_of(input int s);
    return 64'h0000_4000_0000_0000 + 64'h1000 * 64'(s);
  endfunction
  function automatic logic [63:0] b_of(input int s);
    return 64'hFFFF_FFFF_FFFF_FF80 + 64'h11 * 64'(s);
  endfunction

  assign rd_a_val = a_of(int'(rd_a_sel));
  assign rd_b_val = b_of(int'(rd_b_sel));

  vls_addr_seq #(.MAXVL(MAXVL), .IMM_W(IMM_W)) uut (.*);

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nxt(input int c, input logic [15:0] m, input logic v, input int n);
    if (!v) return c;
    for (int p = c; p < n; p++) if (m[p]) return p;
    return n;
  endfunction

  function automatic logic [63:0] ext_b(input logic [63:0] v, input logic [1:0] ew,
                                        input logic s);
    logic [63:0] keep;
    int bits;
    if (ew == 2'd3) return v;
    bits = 8 << ew;
    keep = (64'd1 << bits) - 1;
    if (s && v[bits-1]) return v | ~keep;
    return v & keep;
  endfunction

  logic [63:0] ex_addr [16];
  logic [63:0] ex_wb   [16];
  int          ex_dst  [16];
  int          ex_n;

  task automatic model(input row_t r);
    int i = 0, j = 0, k = 0, u = 0, ia, ib, iu, id, n;
    logic [63:0] a, off, im;
    n = int'(r.vl);
    ex_n = 0;
    im = {{48{r.imm[15]}}, r.imm};
    forever begin
      ia = nxt(i, r.ps, r.rav, n);
      ib = nxt(k, r.ps, r.rbv, n);
      iu = nxt(u, r.ps, r.upv, n);
      id = nxt(j, r.pd, r.rtv, n);
      if (ia >= n || (r.idxf && ib >= n) || (r.upe && iu >= n) || id >= n) break;
      a = a_of(r.rav ? ia : 0);
      off = ext_b(b_of(r.rbv ? ib : 0), r.ew, r.sea);
      case (r.mode)
        3'd0: ex_addr[ex_n] = a + im + 64'(id) * (64'd1 << r.opsz);
        3'd1: ex_addr[ex_n] = a + 64'(id) * im;
        3'd2, 3'd3: ex_addr[ex_n] = a + im;
        3'd4: ex_addr[ex_n] = a;
        3'd5: ex_addr[ex_n] = a + off;
        default: ex_addr[ex_n] = a + off * 64'(id);
      endcase
      ex_wb[ex_n] = (r.mode == 3'd4) ? a + im : ex_addr[ex_n];
      ex_dst[ex_n] = id;
      ex_n++;
      if (!r.rtv) break;
      if (r.rav) i = ia + 1;
      if (r.rbv) k = ib + 1;
      if (r.upv) u = iu + 1;
      j = id + 1;
    end
  endtask

  function automatic string addr_req(input row_t r);
    if (r.idxf && r.ew != 2'd3) return "R7";
    case (r.mode)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2, 3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic load_row(input row_t r);
    idx_form = r.idxf; ra_vec = r.rav; rb_vec = r.rbv; rt_vec = r.rtv;
    upd_en = r.upe; upd_vec = r.upv; els = r.els; postinc = r.pi; sea = r.sea;
    op_size = r.opsz; src_ew = r.ew; imm = r.imm; vl = IW'(r.vl);
    src_mask = r.ps; dst_mask = r.pd;
  endtask

  task automatic run_row(input row_t r);
    int got = 0, cyc = 0;
    bit seen_done = 0, stall = 0;
    logic [63:0] hold = '0;
    model(r);
    load_row(r);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!seen_done && cyc < 400) begin
      out_ready = r.bp ? (cyc % 3 != 1) : 1'b1;
      if (stall) check(out_valid && out_addr == hold, "R10 hold", out_addr, hold);
      if (done) seen_done = 1;
      else if (out_valid) begin
        if (out_ready) begin
          if (got < ex_n) begin
            check(out_addr == ex_addr[got], addr_req(r), out_addr, ex_addr[got]);
            check(int'(out_dst_idx) == ex_dst[got], "R8 dst index",
                  64'(out_dst_idx), 64'(ex_dst[got]));
            check(out_mode == r.mode, "R1 mode", 64'(out_mode), 64'(r.mode));
            if (r.upe) check(out_wb_en && out_wb_val == ex_wb[got],
                             (r.mode == 3'd4) ? "R5 writeback" : "R12 writeback",
                             out_wb_val, ex_wb[got]);
          end
          got++;
          stall = 0;
        end else begin
          stall = 1;
          hold = out_addr;
        end
      end
      @(negedge clk);
      cyc++;
    end
    out_ready = 1'b1;
    check(got == ex_n && got == int'(r.n), r.rtv ? "R8 count" : "R9 count",
          64'(got), 64'(r.n));
    check(seen_done, "R11 done seen", 64'(seen_done), 64'd1);
    check(!done, "R11 done single", 64'(done), 64'd0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!out_valid && !busy && !done, "R11 reset state",
          {61'd0, out_valid, busy, done}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    for (int r = 0; r < NROWS; r++) begin
      run_row(ROWS[r]);
      @(negedge clk);
    end
    // mid-run reset returns to idle
    load_row(ROWS[2]);
    out_ready = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!out_valid && !busy && !done, "R11 reset mid-run",
          {61'd0, out_valid, busy, done}, 64'd0);
    rst = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    // a fresh run after the reset behaves normally
    run_row(ROWS[0]);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule